// File: doc/BRIEF.md
# Activity-Triggered Auto Power-Down Controller

This block decides, on every cycle of a fast system clock, whether a single-bit-wide static memory should be in its high-current active state or in a low-current standby state. It watches the active-low chip enable, the active-low write enable, an 18-bit address and a 1-bit write-data input. Each input is registered once and compared with its previous sampled value. Qualified activity on these inputs is a trigger. A trigger powers the part up and restarts a countdown. When the countdown runs out without a new trigger, the part drops back to standby.

Whether a change counts as a trigger depends on the enable state:
- A chip-enable falling edge always counts.
- A write-enable falling edge counts only while the chip is enabled.
- An address change counts only while the chip is enabled.
- A data change counts only while the chip is enabled and writing.

How long the part stays active depends only on when triggers occur. It does not depend on how long chip enable is held low. Releasing chip enable does not cut an active period short. When the part is not active, it reports one of two standby states: deselected (chip enable high) or selected-but-idle.

The controller is a three-state machine:
- States: `PS_DESEL` (deselected standby), `PS_SEL_STBY` (selected standby) and `PS_ACTIVE`.
- Wake: from either standby state to `PS_ACTIVE` on a trigger.
- Reload: `PS_ACTIVE` to `PS_ACTIVE` on a trigger, which restarts the countdown.
- Expire: `PS_ACTIVE` to a standby state when the countdown reaches zero with no trigger.
- Select and deselect: moves between `PS_DESEL` and `PS_SEL_STBY` that follow the sampled chip enable while the part is not active.

Top module: `apd_power_ctrl`

## Requirements
- R1: Synchronous reset gives `deselected`=1, `pwr_active`=0 and `wake_pulse`=0. Reset loads both sample stages with ce_n=1, we_n=1, address 0 and data 0.
- R2: A chip-enable falling edge between two consecutive samples (previous ce_n=1, newest ce_n=0) is a trigger, whatever the write enable is.
- R3: A write-enable falling edge between two consecutive samples is a trigger only when the newest sample has ce_n=0. With ce_n=1 it has no effect.
- R4: A difference in any address bit between two consecutive samples is a trigger only when the newest sample has ce_n=0.
- R5: A data difference between two consecutive samples is a trigger only when the newest sample has both ce_n=0 and we_n=0.
- R6: An input change applied before clock edge E0 sets `pwr_active` after edge E0+1. After the last trigger, `pwr_active` stays high for exactly PD_CYCLES cycles and then falls, even if ce_n stays low. A trigger during an active period restarts this count.
- R7: A chip-enable rising edge is not a trigger and does not end an active period early. Holding chip enable low without other activity does not extend an active period.
- R8: Whenever `pwr_active` is 0, `deselected` is 1 exactly when the newest sample, taken one edge earlier, has ce_n=1. Otherwise both outputs are 0.
- R9: `wake_pulse` is high for exactly one cycle, in the first cycle of each standby-to-active transition. A reload trigger during an active period produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (18) | Memory address |
| din | input | DATA_W (1) | Write data |
| pwr_active | output | 1 | High-power active state indication |
| deselected | output | 1 | Standby with the chip deselected |
| wake_pulse | output | 1 | One-cycle pulse on entry to the active state |

## Verification
All three results are due two edges after an input change. The first edge registers the input. The second edge moves the state machine and the registered wake pulse. The active period then ends exactly PD_CYCLES edges after the last trigger.

The bench drives inputs on the falling clock edge and compares the outputs on the next falling edge. Each of those comparisons is made against a behavioural model, and model and design advance at the same rising edge. Directed checks count falling edges from the stimulus: two to see a wake, PD_CYCLES−1 more to see the last active cycle, and one more to see standby.

// File: rtl/apd_pkg.sv
package apd_pkg;

    typedef enum logic [1:0] {
        PS_DESEL    = 2'd0,
        PS_SEL_STBY = 2'd1,
        PS_ACTIVE   = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic ce_fall;
        logic we_fall;
        logic addr_chg;
        logic din_chg;
    } trig_src_t;

endpackage

// File: rtl/apd_sampler.sv
module apd_sampler #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              new_ce_n,
    output logic              new_we_n,
    output logic [ADDR_W-1:0] new_addr,
    output logic [DATA_W-1:0] new_din,
    output logic              old_ce_n,
    output logic              old_we_n,
    output logic [ADDR_W-1:0] old_addr,
    output logic [DATA_W-1:0] old_din
);

    // Newest sample: the inputs registered once.
    always_ff @(posedge clk) begin
        if (rst) begin
            new_ce_n <= 1'b1;
            new_we_n <= 1'b1;
            new_addr <= '0;
            new_din  <= '0;
        end else begin
            new_ce_n <= ce_n;
            new_we_n <= we_n;
            new_addr <= addr;
            new_din  <= din;
        end
    end

    // Previous sample, for edge and change detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            old_ce_n <= 1'b1;
            old_we_n <= 1'b1;
            old_addr <= '0;
            old_din  <= '0;
        end else begin
            old_ce_n <= new_ce_n;
            old_we_n <= new_we_n;
            old_addr <= new_addr;
            old_din  <= new_din;
        end
    end

endmodule

// File: rtl/apd_trigger.sv
module apd_trigger
    import apd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 1
) (
    input  logic              new_ce_n,
    input  logic              new_we_n,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [DATA_W-1:0] new_din,
    input  logic              old_ce_n,
    input  logic              old_we_n,
    input  logic [ADDR_W-1:0] old_addr,
    input  logic [DATA_W-1:0] old_din,
    output trig_src_t         src,
    output logic              trig
);

    logic [ADDR_W-1:0] addr_diff;
    logic [DATA_W-1:0] din_diff;

    // Per-line change detectors.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr_cmp
        assign addr_diff[i] = new_addr[i] ^ old_addr[i];
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_din_cmp
        assign din_diff[j] = new_din[j] ^ old_din[j];
    end

    logic selected;
    logic writing;

    assign selected = ~new_ce_n;
    assign writing  = selected & ~new_we_n;

    // Enable-qualified trigger sources.
    always_comb begin
        src.ce_fall  = old_ce_n & ~new_ce_n;
        src.we_fall  = selected & old_we_n & ~new_we_n;
        src.addr_chg = selected & (|addr_diff);
        src.din_chg  = writing & (|din_diff);
    end

    assign trig = src.ce_fall | src.we_fall | src.addr_chg | src.din_chg;

endmodule

// File: rtl/apd_pwr_fsm.sv
module apd_pwr_fsm
    import apd_pkg::*;
#(
    parameter int PD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       sel,
    output pwr_state_e state,
    output logic       pwr_active,
    output logic       deselected,
    output logic       wake_pulse
);

    localparam int               CNT_W  = (PD_CYCLES > 1) ? $clog2(PD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PD_CYCLES - 1);

    pwr_state_e       state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    pwr_state_e       idle_state;

    // Standby flavour when the part is not active.
    assign idle_state = sel ? PS_SEL_STBY : PS_DESEL;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            PS_DESEL, PS_SEL_STBY: begin
                if (trig) begin
                    state_nx = PS_ACTIVE;        // wake
                    cnt_nx   = RELOAD;
                end else begin
                    state_nx = idle_state;       // select / deselect
                end
            end
            PS_ACTIVE: begin
                if (trig) begin
                    state_nx = PS_ACTIVE;        // reload
                    cnt_nx   = RELOAD;
                end else if (cnt == '0) begin
                    state_nx = idle_state;       // expire
                end else begin
                    cnt_nx   = cnt - 1'b1;
                end
            end
            default: begin
                state_nx = PS_DESEL;
                cnt_nx   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_DESEL;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= (state_nx == PS_ACTIVE) && (state != PS_ACTIVE);
        end
    end

    assign pwr_active = (state == PS_ACTIVE);
    assign deselected = (state == PS_DESEL);

    a_r6_trig_enters_active: assert property (@(posedge clk) disable iff (rst)
        trig |=> (state == PS_ACTIVE));

    a_r6_hold_while_counting: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ACTIVE && cnt != '0) |=> (state == PS_ACTIVE));

    a_r7_expire_exits: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ACTIVE && cnt == '0 && !trig) |=> (state != PS_ACTIVE));

    a_r9_wake_single: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    a_r9_wake_on_entry: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (state == PS_ACTIVE && $past(state) != PS_ACTIVE));

    a_r8_idle_tracks_sel: assert property (@(posedge clk) disable iff (rst)
        (!trig && state != PS_ACTIVE) |=> (deselected == !$past(sel)));

endmodule

// File: rtl/apd_power_ctrl.sv
module apd_power_ctrl
    import apd_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 1,
    parameter int PD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              pwr_active,
    output logic              deselected,
    output logic              wake_pulse
);

    logic              s_new_ce_n;
    logic              s_new_we_n;
    logic [ADDR_W-1:0] s_new_addr;
    logic [DATA_W-1:0] s_new_din;
    logic              s_old_ce_n;
    logic              s_old_we_n;
    logic [ADDR_W-1:0] s_old_addr;
    logic [DATA_W-1:0] s_old_din;
    trig_src_t         t_src;
    logic              t_any;
    pwr_state_e        f_state;

    apd_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .new_ce_n (s_new_ce_n),
        .new_we_n (s_new_we_n),
        .new_addr (s_new_addr),
        .new_din  (s_new_din),
        .old_ce_n (s_old_ce_n),
        .old_we_n (s_old_we_n),
        .old_addr (s_old_addr),
        .old_din  (s_old_din)
    );

    apd_trigger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trigger (
        .new_ce_n (s_new_ce_n),
        .new_we_n (s_new_we_n),
        .new_addr (s_new_addr),
        .new_din  (s_new_din),
        .old_ce_n (s_old_ce_n),
        .old_we_n (s_old_we_n),
        .old_addr (s_old_addr),
        .old_din  (s_old_din),
        .src      (t_src),
        .trig     (t_any)
    );

    apd_pwr_fsm #(.PD_CYCLES(PD_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .trig       (t_any),
        .sel        (~s_new_ce_n),
        .state      (f_state),
        .pwr_active (pwr_active),
        .deselected (deselected),
        .wake_pulse (wake_pulse)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (deselected && !pwr_active && !wake_pulse));

    a_r8_exclusive_flags: assert property (@(posedge clk) disable iff (rst)
        !(pwr_active && deselected));

    a_r3_we_ignored_deselected: assert property (@(posedge clk) disable iff (rst)
        (s_new_ce_n && s_old_ce_n) |-> (t_src == '0));

endmodule

// File: tb/test_apd_power_ctrl.sv
`timescale 1ns/1ps
module test_apd_power_ctrl;

    localparam int ADDR_W = 18;
    localparam int P      = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              ce_n, we_n;
    logic [ADDR_W-1:0] addr;
    logic [0:0]        din;
    logic              pwr_active, deselected, wake_pulse;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    apd_power_ctrl #(.ADDR_W(ADDR_W), .DATA_W(1), .PD_CYCLES(P)) i_apd_power_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .pwr_active(pwr_active), .deselected(deselected), .wake_pulse(wake_pulse)
    );

    // Behavioural reference: history of samples {ce_n, we_n, din, addr}.
    localparam logic [20:0] RST_SMP = {1'b1, 1'b1, 1'b0, 18'd0};
    logic [20:0] hist[$];
    int   m_rem   = 0;
    bit   m_wake  = 0;
    bit   m_desel = 1;
    bit   m_valid = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist    = {RST_SMP, RST_SMP};
            m_rem   = 0;
            m_wake  = 0;
            m_desel = 1;
            m_valid = 1;
        end else if (m_valid) begin
            logic [20:0] a, b;
            bit t;
            a = hist[hist.size()-1];
            b = hist[hist.size()-2];
            t = (b[20] && !a[20])
              || (!a[20] && b[19] && !a[19])
              || (!a[20] && a[17:0] != b[17:0])
              || (!a[20] && !a[19] && a[18] != b[18]);
            m_wake = t && (m_rem == 0);
            if (t) m_rem = P;
            else if (m_rem > 0) m_rem = m_rem - 1;
            m_desel = (m_rem == 0) && a[20];
            hist.push_back({ce_n, we_n, din, addr});
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the model.
    always @(negedge clk) begin
        if (m_valid && !rst) begin
            chk("R6 model pwr_active", pwr_active, m_rem > 0);
            chk("R8 model deselected", deselected, m_desel);
            chk("R9 model wake_pulse", wake_pulse, m_wake);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
        step(3);
        chk("R1 deselected", deselected, 1'b1);
        chk("R1 pwr_active", pwr_active, 1'b0);
        chk("R1 wake_pulse", wake_pulse, 1'b0);
        rst = 1'b0;
        step(2);

        // R3 R4 R5 R7: activity while deselected has no effect
        addr = 18'h2A5A5; din = 1'b1; we_n = 1'b0;
        step(3);
        chk("R4 no wake deselected", pwr_active, 1'b0);
        chk("R3 no wake deselected", wake_pulse, 1'b0);
        chk("R8 still deselected", deselected, 1'b1);
        we_n = 1'b1;
        step(3);

        // R2: chip-enable fall wakes; R9 pulse; R6/R7 expiry with CE held low
        ce_n = 1'b0;
        step(2);
        chk("R2 ce fall wakes", pwr_active, 1'b1);
        chk("R9 wake on entry", wake_pulse, 1'b1);
        step(1);
        chk("R9 wake one cycle", wake_pulse, 1'b0);
        step(P - 2);
        chk("R6 last active cycle", pwr_active, 1'b1);
        step(1);
        chk("R7 expires with ce low", pwr_active, 1'b0);
        chk("R8 selected standby", deselected, 1'b0);

        // R4: address change while selected
        addr = 18'h00001;
        step(2);
        chk("R4 addr wakes", pwr_active, 1'b1);
        step(P);
        chk("R6 expired after addr", pwr_active, 1'b0);

        // R5: data change with WE high does nothing
        din = 1'b0;
        step(3);
        chk("R5 no wake we high", pwr_active, 1'b0);
        // R3: WE fall while selected
        we_n = 1'b0;
        step(2);
        chk("R3 we fall wakes", pwr_active, 1'b1);
        step(P);
        chk("R6 expired after we", pwr_active, 1'b0);
        // R5: data change while writing
        din = 1'b1;
        step(2);
        chk("R5 din wakes", pwr_active, 1'b1);
        step(P);

        // R6 R9: retrigger reloads without a pulse
        addr = 18'h3FFFF;
        step(2);
        chk("R6 active again", pwr_active, 1'b1);
        step(3);
        addr = 18'h10000;
        step(2);
        chk("R9 no pulse on reload", wake_pulse, 1'b0);
        step(P - 1);
        chk("R6 reload extends", pwr_active, 1'b1);
        step(1);
        chk("R6 reload expiry", pwr_active, 1'b0);

        // R7: CE rise during activity does not end it early
        addr = 18'h00F0F;
        step(2);
        ce_n = 1'b1;
        step(2);
        chk("R7 ce rise keeps active", pwr_active, 1'b1);
        chk("R8 not deselected while active", deselected, 1'b0);
        step(P);
        chk("R8 deselected after expiry", deselected, 1'b1);

        // R3: WE fall while deselected, then R2 CE fall with WE already low
        we_n = 1'b1;
        step(2);
        we_n = 1'b0;
        step(3);
        chk("R3 we fall ignored", pwr_active, 1'b0);
        ce_n = 1'b0;
        step(2);
        chk("R2 ce fall with we low", pwr_active, 1'b1);
        step(P + 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule